// File: doc/BRIEF.md
# I2C Slave Address-Match Responder

This block is the slave side of a two-wire serial bus. It samples the clock and data lines through synchronizers and a glitch filter. It recognises the start and stop conditions, and it assembles the calling byte: seven address bits, most significant bit first, followed by a direction bit. When the seven bits equal the address on `own_addr`, the block acknowledges in the ninth clock. It then either receives bytes into `rx_data` or sends bytes taken from `tx_data`, one byte at a time.

After every completed byte the block raises `irq` and holds the bus clock low until local logic pulses `irq_clr`. While it holds the clock, local logic can read the received byte or load the next byte to send. A stop releases both lines at once and returns the block to idle. A new start seen without a prior stop releases both lines at once and begins a new address phase. The block drives the bus only through open-drain enables: a 1 on `scl_oe` or `sda_oe` pulls that line low.

Top module: `i2c_addr_responder`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `irq` and `addressed` are all 0.
- R2: After a start, the first eight bits sampled on SCL rising edges form the calling byte: address bits 7..1 sent MSB first, then the direction bit in bit 0. When address bits 7..1 equal `own_addr`, SDA is pulled low for the whole ninth clock and `addressed` goes to 1.
- R3: When the calling address does not match, SDA stays released in the ninth clock and for every later clock until the next start. `irq` stays 0 and `addressed` stays 0.
- R4: At the falling edge that ends the ninth clock of each acknowledged byte, `irq` becomes 1 and `scl_oe` holds SCL low. Both return to 0 within a few cycles of a one-cycle pulse on `irq_clr`, and not before it.
- R5: With direction bit 0 and `rx_full` = 0, each 8-bit data byte, MSB first, appears on `rx_data` and is acknowledged.
- R6: With `rx_full` = 1 during a received data byte, the ninth clock carries a NACK: SDA is left released.
- R7: With direction bit 1, the byte on `tx_data` is captured when `irq_clr` ends the hold and is sent MSB first. SDA changes only while SCL is low.
- R8: If the master leaves SDA high in the ninth clock after a transmitted byte, `irq` stays 0, `addressed` drops to 0, and SDA stays released until the next start.
- R9: A stop (SDA rising while SCL is high) releases SDA and SCL and clears `addressed`, even in the middle of a byte. Bus clocks that follow without a new start are not acknowledged.
- R10: A start without a preceding stop releases the bus and begins a new address phase straight away. Both a mismatch and a match with the other direction are then handled as in R2 and R3.
- R11: A low pulse on SDA lasting one system clock while SCL is high is filtered out. It neither starts nor stops a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| scl_oe | output | 1 | 1 pulls the bus clock low (clock stretching) |
| sda_oe | output | 1 | 1 pulls the bus data line low |
| own_addr | input | DATA_W-1 | Seven-bit slave address |
| tx_data | input | DATA_W | Next byte to send in read transfers |
| rx_full | input | 1 | When 1, received data bytes get a NACK |
| irq_clr | input | 1 | One-cycle pulse that clears `irq` and ends the clock hold |
| irq | output | 1 | Byte-complete flag |
| rx_data | output | DATA_W | Last received data byte |
| addressed | output | 1 | 1 while the block is the selected slave |

## Verification
A wrong bit counter or a stale state shows up on the ninth clock of the same byte: the acknowledge appears a clock early or late, or not at all. `irq` then fails to rise, or the clock hold never starts and the master keeps clocking. A missed stop or repeated start shows up one byte later, because the block acknowledges or drives bits it should have dropped. A fault in the transmit shifter shows up on the bus within the byte, either as a wrong bit or as SDA changing while SCL is high.

// File: rtl/i2c_resp_pkg.sv
package i2c_resp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_SKIP
  } resp_state_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   filt_q;
  logic                   filt_d;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  // accept a level only once it has been seen on two consecutive samples
  always_comb begin
    filt_d = filt_q;
    if (synced == last_q) filt_d = synced;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
      filt_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      last_q <= synced;
      filt_q <= filt_d;
    end
  end

  assign line_o = filt_q;
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic ev_start,
  output logic ev_stop,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign ev_start = scl_f & scl_q & sda_q & ~sda_f;
  assign ev_stop  = scl_f & scl_q & ~sda_q & sda_f;
  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import i2c_resp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic [DATA_W-2:0] own_addr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_full,
  input  logic              irq_clr,
  output logic              scl_hold,
  output logic              sda_low,
  output logic              irq,
  output logic [DATA_W-1:0] rx_data,
  output logic              addressed
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  resp_state_e       state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic              sda_q, sda_d;
  logic              hold_q, hold_d;
  logic              irq_q, irq_d;
  logic              sel_q, sel_d;
  logic              rw_q, rw_d;
  logic              ack_q, ack_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shift_d = shift_q;
    rx_d    = rx_q;
    sda_d   = sda_q;
    hold_d  = hold_q;
    irq_d   = irq_q;
    sel_d   = sel_q;
    rw_d    = rw_q;
    ack_d   = ack_q;

    if (irq_clr) begin
      irq_d  = 1'b0;
      hold_d = 1'b0;
      if (hold_q && state_q == ST_TX) begin
        shift_d = tx_data;
        sda_d   = ~tx_data[DATA_W-1];
      end
    end

    if (ev_stop) begin
      state_d = ST_IDLE;
      sda_d   = 1'b0;
      hold_d  = 1'b0;
      sel_d   = 1'b0;
    end else if (ev_start) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      sda_d   = 1'b0;
      hold_d  = 1'b0;
      sel_d   = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_RX: begin
          if (scl_rise) begin
            shift_d = {shift_q[DATA_W-2:0], sda_f};
            cnt_d   = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            cnt_d = '0;
            if (state_q == ST_ADDR) begin
              if (shift_q[DATA_W-1:1] == own_addr) begin
                state_d = ST_ADDR_ACK;
                sda_d   = 1'b1;
                sel_d   = 1'b1;
                rw_d    = shift_q[0];
              end else begin
                state_d = ST_SKIP;
              end
            end else begin
              rx_d    = shift_q;
              sda_d   = ~rx_full;
              state_d = ST_RX_ACK;
            end
          end
        end
        ST_ADDR_ACK, ST_RX_ACK: begin
          if (scl_fall) begin
            sda_d   = 1'b0;
            irq_d   = 1'b1;
            hold_d  = 1'b1;
            cnt_d   = '0;
            state_d = (state_q == ST_RX_ACK || !rw_q) ? ST_RX : ST_TX;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              sda_d   = 1'b0;
              cnt_d   = '0;
              state_d = ST_TX_ACK;
            end else begin
              cnt_d   = cnt_q + 1'b1;
              shift_d = shift_q << 1;
              sda_d   = ~shift_q[DATA_W-2];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            ack_d = ~sda_f;
          end else if (scl_fall) begin
            if (ack_q) begin
              irq_d   = 1'b1;
              hold_d  = 1'b1;
              state_d = ST_TX;
            end else begin
              state_d = ST_SKIP;
              sel_d   = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      rx_q    <= '0;
      sda_q   <= 1'b0;
      hold_q  <= 1'b0;
      irq_q   <= 1'b0;
      sel_q   <= 1'b0;
      rw_q    <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      rx_q    <= rx_d;
      sda_q   <= sda_d;
      hold_q  <= hold_d;
      irq_q   <= irq_d;
      sel_q   <= sel_d;
      rw_q    <= rw_d;
      ack_q   <= ack_d;
    end
  end

  assign scl_hold  = hold_q;
  assign sda_low   = sda_q;
  assign irq       = irq_q;
  assign rx_data   = rx_q;
  assign addressed = sel_q;

  // SDA drive moves only after SCL was seen low, or on a bus condition
  assert_sda_moves_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_q) |-> (!$past(scl_f) || $past(ev_start) || $past(ev_stop)));

  assert_skip_keeps_sda_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP) |-> !sda_q);

  assert_stop_releases_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (!sda_q && !hold_q && !sel_q));

  assert_hold_only_with_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> irq_q);
endmodule

// File: rtl/i2c_addr_responder.sv
module i2c_addr_responder #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [DATA_W-2:0] own_addr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_full,
  input  logic              irq_clr,
  output logic              irq,
  output logic [DATA_W-1:0] rx_data,
  output logic              addressed
);
  localparam int LINES = 2;

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [LINES-1:0] raw_lines;
  logic [LINES-1:0] filt_lines;
  logic             ev_start, ev_stop, scl_rise, scl_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filter (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .line_i (raw_lines[g]),
      .line_o (filt_lines[g])
    );
  end

  i2c_bus_events u_events (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .scl_f    (filt_lines[0]),
    .sda_f    (filt_lines[1]),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall)
  );

  i2c_slave_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ev_start  (ev_start),
    .ev_stop   (ev_stop),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .scl_f     (filt_lines[0]),
    .sda_f     (filt_lines[1]),
    .own_addr  (own_addr),
    .tx_data   (tx_data),
    .rx_full   (rx_full),
    .irq_clr   (irq_clr),
    .scl_hold  (scl_oe),
    .sda_low   (sda_oe),
    .irq       (irq),
    .rx_data   (rx_data),
    .addressed (addressed)
  );
endmodule

// File: tb/i2c_addr_responder_tb.sv
module i2c_addr_responder_tb;
  localparam int Q = 8;
  localparam logic [6:0] OWN = 7'h5A;
  localparam int NVEC = 5;
  // {address[6:0], data[7:0], rx_full}
  localparam logic [15:0] VEC [NVEC] = '{
    {7'h5A, 8'hA5, 1'b0},
    {7'h5A, 8'h3C, 1'b1},
    {7'h5B, 8'hFF, 1'b0},
    {7'h1A, 8'h00, 1'b0},
    {7'h5A, 8'h81, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic m_scl, m_sda;
  logic scl_bus, sda_bus;
  logic scl_oe, sda_oe, irq, addressed;
  logic [7:0] tx_data, rx_data;
  logic rx_full, irq_clr;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  assign scl_bus = m_scl & ~scl_oe;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_addr_responder u_dut (
    .clk (clk), .rst_n (rst_n), .scl_i (scl_bus), .sda_i (sda_bus),
    .scl_oe (scl_oe), .sda_oe (sda_oe), .own_addr (OWN), .tx_data (tx_data),
    .rx_full (rx_full), .irq_clr (irq_clr), .irq (irq), .rx_data (rx_data),
    .addressed (addressed)
  );

  task automatic check_eq(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high;
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wclk(Q);
    m_scl = 1'b1; wait_scl_high; wclk(Q);
    m_sda = 1'b0; wclk(Q);
    m_scl = 1'b0; wclk(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wclk(Q);
    m_scl = 1'b1; wait_scl_high; wclk(Q);
    m_sda = 1'b1; wclk(Q);
  endtask

  task automatic send_bit(logic b, bit glitch);
    m_sda = b; wclk(Q);
    m_scl = 1'b1; wait_scl_high; wclk(Q/2);
    if (glitch) begin m_sda = 1'b0; wclk(1); m_sda = b; end
    wclk(Q/2);
    m_scl = 1'b0; wclk(Q);
  endtask

  task automatic recv_bit(output logic b, output logic steady);
    logic first;
    m_sda = 1'b1; wclk(Q);
    m_scl = 1'b1; wait_scl_high; wclk(1);
    first = sda_bus; wclk(Q-1);
    steady = (sda_bus == first);
    b = first;
    m_scl = 1'b0; wclk(Q);
  endtask

  task automatic send_byte(logic [7:0] d, output logic acked);
    logic b, s;
    for (int i = 7; i >= 0; i--) send_bit(d[i], 1'b0);
    recv_bit(b, s);
    acked = !b;
  endtask

  task automatic recv_byte(output logic [7:0] d, output logic steady_all);
    logic b, s;
    steady_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b, s);
      d[i] = b;
      steady_all &= s;
    end
  endtask

  // R4: hold persists until irq_clr, then both drop
  task automatic service_irq;
    wclk(20);
    check_eq("R4", "scl held before clear", scl_oe, 1);
    irq_clr = 1'b1; wclk(1); irq_clr = 1'b0; wclk(3);
    check_eq("R4", "scl released after clear", scl_oe, 0);
    check_eq("R4", "irq cleared", irq, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] vec;
    logic [6:0] a;
    logic [7:0] d, got;
    logic full, exp_a, ack, st, b;

    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
    tx_data = 8'h00; rx_full = 1'b0; irq_clr = 1'b0;
    wclk(5); rst_n = 1'b1; wclk(10);

    // R1 reset state
    check_eq("R1", "scl_oe", scl_oe, 0);
    check_eq("R1", "sda_oe", sda_oe, 0);
    check_eq("R1", "irq", irq, 0);
    check_eq("R1", "addressed", addressed, 0);

    // vector table: write transfers
    for (int v = 0; v < NVEC; v++) begin
      vec = VEC[v];
      a = vec[15:9]; d = vec[8:1]; full = vec[0];
      exp_a = (a == OWN);
      rx_full = full;
      bus_start;
      send_byte({a, 1'b0}, ack);
      check_eq(exp_a ? "R2" : "R3", "address ack", ack, exp_a);
      check_eq(exp_a ? "R2" : "R3", "addressed", addressed, exp_a);
      if (exp_a) begin
        check_eq("R4", "irq after address", irq, 1);
        service_irq;
      end
      send_byte(d, ack);
      check_eq(exp_a ? (full ? "R6" : "R5") : "R3", "data ack", ack, exp_a && !full);
      if (exp_a) begin
        check_eq("R5", "rx_data", rx_data, d);
        check_eq("R4", "irq after data", irq, 1);
        service_irq;
      end else begin
        check_eq("R3", "irq stays low", irq, 0);
      end
      bus_stop;
      check_eq("R9", "addressed after stop", addressed, 0);
      check_eq("R9", "sda released after stop", sda_oe, 0);
    end
    rx_full = 1'b0;

    // R7 / R8: read transfer
    bus_start;
    send_byte({OWN, 1'b1}, ack);
    check_eq("R2", "read address ack", ack, 1);
    tx_data = 8'hC6;
    service_irq;
    recv_byte(got, st);
    check_eq("R7", "first tx byte", got, 8'hC6);
    check_eq("R7", "sda steady while scl high", st, 1);
    send_bit(1'b0, 1'b0);
    check_eq("R4", "irq after master ack", irq, 1);
    tx_data = 8'h3B;
    service_irq;
    recv_byte(got, st);
    check_eq("R7", "second tx byte", got, 8'h3B);
    check_eq("R7", "second byte steady", st, 1);
    send_bit(1'b1, 1'b0);
    check_eq("R8", "irq after master nack", irq, 0);
    check_eq("R8", "addressed after nack", addressed, 0);
    check_eq("R8", "scl not held", scl_oe, 0);
    recv_byte(got, st);
    check_eq("R8", "sda released after nack", got, 8'hFF);
    bus_stop;

    // R9: stop in the middle of a data byte
    bus_start;
    send_byte({OWN, 1'b0}, ack);
    check_eq("R9", "setup ack", ack, 1);
    service_irq;
    send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0);
    bus_stop;
    check_eq("R9", "addressed after mid-byte stop", addressed, 0);
    m_scl = 1'b0; wclk(Q);
    send_byte({OWN, 1'b0}, ack);
    check_eq("R9", "no ack without start", ack, 0);
    check_eq("R9", "no irq without start", irq, 0);
    bus_stop;

    // R10: repeated start
    bus_start;
    send_byte({OWN, 1'b0}, ack);
    check_eq("R10", "first address ack", ack, 1);
    service_irq;
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
    bus_start;
    send_byte({7'h22, 1'b0}, ack);
    check_eq("R10", "foreign address after restart", ack, 0);
    check_eq("R10", "addressed after foreign", addressed, 0);
    bus_start;
    send_byte({OWN, 1'b1}, ack);
    check_eq("R10", "own read address after restart", ack, 1);
    check_eq("R10", "irq after restart", irq, 1);
    tx_data = 8'h5F;
    service_irq;
    recv_bit(b, st);
    check_eq("R10", "first read bit after restart", b, 0);
    bus_stop;

    // R11: one-sample SDA glitch while SCL high inside the address
    bus_start;
    for (int i = 7; i >= 0; i--) send_bit(OWN_BYTE(i), i == 7);
    recv_bit(b, st);
    check_eq("R11", "ack despite glitch", !b, 1);
    check_eq("R11", "addressed despite glitch", addressed, 1);
    service_irq;
    bus_stop;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  function automatic logic OWN_BYTE(int i);
    logic [7:0] w;
    w = {OWN, 1'b0};
    return w[i];
  endfunction
endmodule